// File: doc/BRIEF.md
# Multiplexed MDIO Management Master

This block is a register-driven MDIO management master. Software sets up a parameter word, which holds the child-bus selection, the clause, the PHY address and the write data. It also sets up an address word. It then writes an operation code to the control register. A single transaction engine turns that request into one or two serial management frames on MDC/MDIO. The frames go to exactly one of several child buses. The child buses are split into an internal group and an external group.

The engine divides the system clock to produce MDC. Each frame starts with 32 preamble ones. A Clause 22 access is one frame. A Clause 45 access is an address frame followed by a write or read frame. For reads, the master releases MDIO at turnaround, shifts in 16 data bits on rising MDC, and presents them in the read-data register. A done flag in the status register reports completion. The done flag stays set until software writes zero to the control register. Writing zero is also the only way to re-arm the engine or to abort a frame in progress.

The register port is a plain single-cycle interface with no back-pressure. A write takes effect on the clock edge where `reg_wen` is high. Read data is a combinational function of `reg_addr`. No data stream crosses the block's edge, so it has no valid/ready handshake.

Top module: `mdmx_top`

## Requirements
- R1: Registers sit at byte offsets 0x00 parameters, 0x04 read data, 0x08 address, 0x0C control and 0x10 status. The parameter register keeps bits 25:0 and reads zero above them. The address register keeps all 32 bits. Control and any unmapped offset read as zero.
- R2: Writing exactly 1 to control starts a write access and exactly 2 starts a read. Any other nonzero value starts nothing.
- R3: Status bit 0 reads 0 while idle or busy and 1 after the access completes. It stays 1, and further start codes are ignored, until control is written with 0.
- R4: Writing 0 to control during an access stops it at once. MDC goes low, all output enables drop, status reads 0, and no further MDC edges appear.
- R5: With parameter bit 21 clear, one frame is sent. It is 32 ones, start 01, opcode 01 (write) or 10 (read), PHY address = parameter bits 20:16, register = address bits 4:0, turnaround 10, then 16 data bits MSB first (parameter bits 15:0 for writes).
- R6: With parameter bit 21 set, two frames are sent, both with start 00. The first has opcode 00, device = address bits 20:16 and data = address bits 15:0. The second has opcode 01 (write, data = parameter bits 15:0) or 11 (read), with the same device field.
- R7: In a read frame the master's output enable is low from the first turnaround bit to the end. MDIO is sampled at each rising MDC of the 16 data bits, and the value appears MSB first in read-data bits 15:0, with bits 31:16 zero.
- R8: Parameter bit 25 set with bus id k (bits 24:22) selects internal child k. Bit 25 clear selects external child k, which is port index NUM_INT+k. An id beyond its group selects no child, and a read then returns 0xFFFF.
- R9: At most one child bus toggles MDC at any time. Every unselected child holds MDC low and its output enable low.
- R10: MDC has a period of 2*MDC_HALF system clocks, with each bit's low half first. MDC is low whenever no access is running.
- R11: Selection and frame fields are captured at the start. Register writes during an access do not change the frames being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Register byte offset |
| reg_wen | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mdc_o | output | NUM_INT+NUM_EXT | MDC per child bus |
| mdio_o | output | NUM_INT+NUM_EXT | MDIO output value per child bus |
| mdio_oe | output | NUM_INT+NUM_EXT | MDIO output enable per child bus |
| mdio_i | input | NUM_INT+NUM_EXT | MDIO input per child bus |

## Verification
The bench builds the block with two internal and three external child buses and MDC_HALF of 2, so each frame lasts 256 clocks. With this setup, a sweep over all sixteen combinations of group flag and bus id runs in a few thousand cycles. The sweep covers every valid child and every out-of-range id in both groups. A small behavioural PHY on the selected child decodes every frame bit and answers reads. This lets the bench check the Clause 22 and Clause 45 layouts, the read turnaround and readback, aborts, ignored start codes and mid-access register writes against arithmetically built frame words.

// File: rtl/mdmx_pkg.sv
`timescale 1ns/1ps
package mdmx_pkg;
  localparam int REG_AW = 5;
  localparam logic [REG_AW-1:0] OFS_PARAM = 5'h00;
  localparam logic [REG_AW-1:0] OFS_RDATA = 5'h04;
  localparam logic [REG_AW-1:0] OFS_ADDR  = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_STAT  = 5'h10;

  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int DATA_FIRST = 48;

  typedef enum logic [1:0] {ENG_IDLE, ENG_RUN, ENG_DONE} eng_state_t;

  // Packed so that internal lands on bit 25 and wdata on bits 15:0.
  typedef struct packed {
    logic        internal;
    logic [2:0]  bus_id;
    logic        c45;
    logic [4:0]  phy;
    logic [15:0] wdata;
  } mdio_param_t;
endpackage

// File: rtl/mdmx_regs.sv
`timescale 1ns/1ps
module mdmx_regs
  import mdmx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              done,
  input  logic [15:0]       rd_word,
  output mdio_param_t       param_q,
  output logic [20:0]       addr_field,
  output logic              start_wr,
  output logic              start_rd,
  output logic              clr
);
  logic [31:0] addr_q;
  logic        ctrl_we;

  assign ctrl_we    = bus_wen && (bus_addr == OFS_CTRL);
  assign start_wr   = ctrl_we && (bus_wdata == 32'd1);
  assign start_rd   = ctrl_we && (bus_wdata == 32'd2);
  assign clr        = ctrl_we && (bus_wdata == 32'd0);
  assign addr_field = addr_q[20:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      param_q <= '0;
      addr_q  <= '0;
    end else if (bus_wen) begin
      if (bus_addr == OFS_PARAM) param_q <= mdio_param_t'(bus_wdata[25:0]);
      if (bus_addr == OFS_ADDR)  addr_q  <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_PARAM: bus_rdata = {6'd0, param_q};
      OFS_RDATA: bus_rdata = {16'd0, rd_word};
      OFS_ADDR:  bus_rdata = addr_q;
      OFS_STAT:  bus_rdata = {31'd0, done};
      default:   bus_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/mdmx_mdc_div.sv
`timescale 1ns/1ps
module mdmx_mdc_div #(
  parameter int HALF = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic bit_end,
  output logic sample
);
  localparam int PER = 2 * HALF;
  localparam int CW  = (PER > 2) ? $clog2(PER) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)             cnt <= '0;
    else if (cnt == CW'(PER - 1))   cnt <= '0;
    else                            cnt <= cnt + 1'b1;
  end

  assign bit_end = run && (cnt == CW'(PER - 1));
  assign sample  = run && (cnt == CW'(HALF - 1));
  assign mdc     = run && (cnt >= CW'(HALF));

  // MDC may only change at the half boundary or at the bit boundary.
  assert_mdc_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && cnt != '0 && cnt != CW'(HALF)) |-> $stable(mdc));
endmodule

// File: rtl/mdmx_engine.sv
`timescale 1ns/1ps
module mdmx_engine
  import mdmx_pkg::*;
#(
  parameter int MDC_HALF = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_wr,
  input  logic        start_rd,
  input  logic        clr,
  input  mdio_param_t param,
  input  logic [20:0] addr,
  input  logic        din,
  output logic        busy,
  output logic        done,
  output logic        mdc,
  output logic        dout,
  output logic        oe,
  output logic [15:0] rd_word,
  output logic        sel_int,
  output logic [2:0]  sel_id
);
  eng_state_t  st_q;
  mdio_param_t lp;
  logic        l_rd;
  logic [20:0] l_addr;
  logic        frame_q;
  logic [5:0]  bit_q;
  logic        run, bit_end, sample, last;
  logic [1:0]  st2, op2;
  logic [4:0]  f2;
  logic [15:0] d16;
  logic [FRAME_BITS-1:0] fword;

  assign run = (st_q == ENG_RUN);

  mdmx_mdc_div #(.HALF(MDC_HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run),
    .mdc(mdc), .bit_end(bit_end), .sample(sample)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ENG_IDLE;
      lp      <= '0;
      l_rd    <= 1'b0;
      l_addr  <= '0;
      frame_q <= 1'b0;
      bit_q   <= '0;
    end else if (clr) begin
      st_q <= ENG_IDLE;
    end else begin
      case (st_q)
        ENG_IDLE: if (start_wr || start_rd) begin
          st_q    <= ENG_RUN;
          lp      <= param;
          l_rd    <= start_rd;
          l_addr  <= addr;
          frame_q <= 1'b0;
          bit_q   <= '0;
        end
        ENG_RUN: if (bit_end) begin
          bit_q <= bit_q + 1'b1;
          if (bit_q == 6'(FRAME_BITS - 1)) begin
            if (last) st_q    <= ENG_DONE;
            else      frame_q <= 1'b1;
          end
        end
        default: st_q <= st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_word <= '0;
    else if (sample && last && l_rd && bit_q >= 6'(DATA_FIRST))
      rd_word <= {rd_word[14:0], din};
  end

  // Frame word assembly: the final frame of an access carries the operation.
  always_comb begin
    last = (frame_q == lp.c45);
    st2  = lp.c45 ? 2'b00 : 2'b01;
    if (!last)     op2 = 2'b00;
    else if (l_rd) op2 = lp.c45 ? 2'b11 : 2'b10;
    else           op2 = 2'b01;
    f2    = lp.c45 ? l_addr[20:16] : l_addr[4:0];
    d16   = last ? lp.wdata : l_addr[15:0];
    fword = {32'hFFFF_FFFF, st2, op2, lp.phy, f2, 2'b10, d16};
  end

  assign dout    = fword[6'd63 - bit_q];
  assign oe      = run && !(last && l_rd && bit_q >= 6'(TA_FIRST));
  assign busy    = run;
  assign done    = (st_q == ENG_DONE);
  assign sel_int = lp.internal;
  assign sel_id  = lp.bus_id;

  assert_fields_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable({lp, l_rd, l_addr}));

  assert_read_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && l_rd && last && bit_q >= 6'(DATA_FIRST)) |-> !oe);
endmodule

// File: rtl/mdmx_fanout.sv
`timescale 1ns/1ps
module mdmx_fanout #(
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 4
) (
  input  logic               sel_int,
  input  logic [2:0]         sel_id,
  input  logic               mdc,
  input  logic               dout,
  input  logic               oe,
  input  logic [NUM_INT+NUM_EXT-1:0] mdio_i,
  output logic [NUM_INT+NUM_EXT-1:0] mdc_o,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_o,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_oe,
  output logic               din
);
  localparam int NC = NUM_INT + NUM_EXT;
  logic [NC-1:0] hit;

  for (genvar i = 0; i < NC; i++) begin : g_child
    if (i < NUM_INT) begin : g_int
      assign hit[i] = sel_int && (sel_id == 3'(i));
    end else begin : g_ext
      assign hit[i] = !sel_int && (sel_id == 3'(i - NUM_INT));
    end
    assign mdc_o[i]   = hit[i] && mdc;
    assign mdio_o[i]  = hit[i] && dout;
    assign mdio_oe[i] = hit[i] && oe;
  end

  // No selected child: the line floats high through its pull-up.
  assign din = (|hit) ? |(hit & mdio_i) : 1'b1;
endmodule

// File: rtl/mdmx_top.sv
`timescale 1ns/1ps
module mdmx_top
  import mdmx_pkg::*;
#(
  parameter int NUM_INT  = 4,
  parameter int NUM_EXT  = 4,
  parameter int MDC_HALF = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [4:0]                 reg_addr,
  input  logic                       reg_wen,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  output logic [NUM_INT+NUM_EXT-1:0] mdc_o,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_o,
  output logic [NUM_INT+NUM_EXT-1:0] mdio_oe,
  input  logic [NUM_INT+NUM_EXT-1:0] mdio_i
);
  mdio_param_t param_q;
  logic [20:0] addr_field;
  logic        start_wr, start_rd, clr;
  logic        busy, done, mdc, dout, oe, din, sel_int;
  logic [2:0]  sel_id;
  logic [15:0] rd_word;

  mdmx_regs u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(reg_addr), .bus_wen(reg_wen),
    .bus_wdata(reg_wdata), .bus_rdata(reg_rdata), .done(done),
    .rd_word(rd_word), .param_q(param_q), .addr_field(addr_field),
    .start_wr(start_wr), .start_rd(start_rd), .clr(clr)
  );

  mdmx_engine #(.MDC_HALF(MDC_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd),
    .clr(clr), .param(param_q), .addr(addr_field), .din(din),
    .busy(busy), .done(done), .mdc(mdc), .dout(dout), .oe(oe),
    .rd_word(rd_word), .sel_int(sel_int), .sel_id(sel_id)
  );

  mdmx_fanout #(.NUM_INT(NUM_INT), .NUM_EXT(NUM_EXT)) u_fan (
    .sel_int(sel_int), .sel_id(sel_id), .mdc(mdc), .dout(dout), .oe(oe),
    .mdio_i(mdio_i), .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .din(din)
  );

  assert_one_child_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mdc_o) && $onehot0(mdio_oe));

  assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> done);

  assert_abort_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!done && !busy && mdc_o == '0 && mdio_oe == '0));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mdc_o == '0));
endmodule

// File: tb/mdmx_top_test.sv
`timescale 1ns/1ps
module mdmx_top_test;
  localparam int NI = 2, NE = 3, H = 2, NC = NI + NE;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic          reg_wen = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] mdc_o, mdio_o, mdio_oe;
  logic [NC-1:0] mdio_i = '1;

  mdmx_top #(.NUM_INT(NI), .NUM_EXT(NE), .MDC_HALF(H)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc_o(mdc_o),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_err = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk); reg_wen = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  // Behavioural PHY and line monitor on the expected child.
  int          tgt = -1, g = 0, stray = 0, per_err = 0, since = 0;
  logic        rec_d [0:127];
  logic        rec_oe[0:127];
  logic [NC-1:0] mdc_prev = '0;
  bit          e_c45, e_rd;
  logic [15:0] e_resp, e_wd;
  logic [4:0]  e_phy;
  logic [31:0] e_addr;
  int          e_tgt;
  string       e_tag;

  function automatic logic resp_bit(input int gi);
    int f = gi / 64, p = gi % 64;
    if (e_rd && f == (e_c45 ? 1 : 0)) begin
      if (p == 47) return 1'b0;
      if (p >= 48) return e_resp[63 - p];
    end
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    for (int j = 0; j < NC; j++)
      if (mdc_o[j] && j != tgt) stray++;
    if (tgt >= 0 && mdc_o[tgt] && !mdc_prev[tgt]) begin
      if (g > 0 && since != 2 * H) per_err++;
      since = 0;
      if (g < 128) begin rec_d[g] = mdio_o[tgt]; rec_oe[g] = mdio_oe[tgt]; end
      g++;
      mdio_i[tgt] = resp_bit(g);
    end
    since++;
    mdc_prev = mdc_o;
  end

  function automatic logic [63:0] exp_word(input bit c45, input bit rd, input bit last,
      input logic [4:0] phy, input logic [31:0] ad, input logic [15:0] wd);
    logic [63:0] w;
    logic [1:0] op;
    op = !last ? 2'd0 : (rd ? (c45 ? 2'd3 : 2'd2) : 2'd1);
    w = 64'hFFFF_FFFF_0000_0000;
    w |= 64'(c45 ? 0 : 1) << 30;
    w |= 64'(op) << 28;
    w |= 64'(phy) << 23;
    w |= 64'(c45 ? ad[20:16] : ad[4:0]) << 18;
    w |= 64'd2 << 16;
    w |= 64'(last ? wd : ad[15:0]);
    return w;
  endfunction

  task automatic start_op(input int ii, input int id, input bit c45, input bit rd,
      input logic [4:0] phy, input logic [15:0] wd, input logic [31:0] ad,
      input logic [15:0] rsp, input string tag);
    logic [31:0] v;
    int t;
    if (ii != 0) t = (id < NI) ? id : -1;
    else         t = (id < NE) ? NI + id : -1;
    bus_wr(5'h00, (32'(ii) << 25) | (32'(id) << 22) | (32'(c45) << 21) | (32'(phy) << 16) | 32'(wd));
    bus_wr(5'h08, ad);
    bus_wr(5'h0C, 32'd0);
    #1;
    g = 0; stray = 0; per_err = 0; since = 0; mdio_i = '1;
    e_c45 = c45; e_rd = rd; e_resp = rsp; e_wd = wd; e_phy = phy;
    e_addr = ad; e_tgt = t; e_tag = tag; tgt = t;
    bus_wr(5'h0C, rd ? 32'd2 : 32'd1);
    bus_rd(5'h10, v);
    check($sformatf("R3 busy status %s", tag), v, 32'd0);
  endtask

  task automatic finish_op();
    logic [31:0] v;
    int nf, mism;
    logic [63:0] w;
    v = '0;
    for (int k = 0; k < 3000; k++) begin
      bus_rd(5'h10, v);
      if (v[0]) break;
    end
    check($sformatf("R3 done %s", e_tag), v, 32'd1);
    nf = e_c45 ? 2 : 1;
    check($sformatf("R8 bit count %s", e_tag), 32'(g), 32'(e_tgt >= 0 ? 64 * nf : 0));
    check($sformatf("R9 stray clock %s", e_tag), 32'(stray), 32'd0);
    check($sformatf("R10 period %s", e_tag), 32'(per_err), 32'd0);
    check($sformatf("R10 idle low %s", e_tag), 32'(mdc_o), 32'd0);
    if (e_tgt >= 0) begin
      mism = 0;
      for (int f = 0; f < nf; f++) begin
        w = exp_word(e_c45, e_rd, f == nf - 1, e_phy, e_addr, e_wd);
        for (int p = 0; p < 64; p++) begin
          if (e_rd && f == nf - 1 && p >= 46) begin
            if (rec_oe[64 * f + p] !== 1'b0) mism++;
          end else if (rec_oe[64 * f + p] !== 1'b1 || rec_d[64 * f + p] !== w[63 - p]) begin
            mism++;
          end
        end
      end
      check($sformatf("%s frame bits %s R2", e_c45 ? "R6" : "R5", e_tag), 32'(mism), 32'd0);
    end
    if (e_rd) begin
      bus_rd(5'h04, v);
      check($sformatf("R7 read data %s", e_tag), v, {16'd0, e_tgt >= 0 ? e_resp : 16'hFFFF});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int gs;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    bus_rd(5'h10, v); check("R3 reset status", v, 32'd0);
    bus_rd(5'h00, v); check("R1 reset param", v, 32'd0);
    bus_rd(5'h04, v); check("R1 reset rdata", v, 32'd0);
    check("R10 reset mdc", 32'(mdc_o), 32'd0);
    check("R9 reset oe", 32'(mdio_oe), 32'd0);

    // Register readback
    bus_wr(5'h00, 32'hFFFF_FFFF); bus_rd(5'h00, v); check("R1 param width", v, 32'h03FF_FFFF);
    bus_wr(5'h08, 32'h8012_ABCD); bus_rd(5'h08, v); check("R1 addr readback", v, 32'h8012_ABCD);
    bus_rd(5'h0C, v); check("R1 ctrl reads zero", v, 32'd0);
    bus_rd(5'h14, v); check("R1 unmapped 0x14", v, 32'd0);
    bus_rd(5'h1C, v); check("R1 unmapped 0x1C", v, 32'd0);

    // Selection sweep with Clause 22 writes
    for (int ii = 0; ii < 2; ii++)
      for (int id = 0; id < 8; id++) begin
        start_op(ii, id, 1'b0, 1'b0, 5'(id * 5 + ii), 16'hA5C3 ^ 16'(id * 257),
                 32'(id + ii * 8 + 1), 16'h0, $sformatf("R8 sweep int=%0d id=%0d", ii, id));
        finish_op();
      end

    // Clause 22 reads on every valid child
    for (int id = 0; id < NI; id++) begin
      start_op(1, id, 1'b0, 1'b1, 5'(7 + id), 16'h0, 32'(3 + id),
               16'h8001 + 16'(id * 16'h1357), $sformatf("R7 c22 rd int %0d", id));
      finish_op();
    end
    for (int id = 0; id < NE; id++) begin
      start_op(0, id, 1'b0, 1'b1, 5'(20 + id), 16'h0, 32'(30 - id),
               16'h4E21 ^ 16'(id * 16'h0F0F), $sformatf("R7 c22 rd ext %0d", id));
      finish_op();
    end
    start_op(1, 5, 1'b0, 1'b1, 5'd1, 16'h0, 32'd2, 16'h1234, "R8 out of range read");
    finish_op();

    // Clause 45 accesses
    start_op(1, 0, 1'b1, 1'b0, 5'd9, 16'hC0DE, {11'd0, 5'd3, 16'h2001}, 16'h0, "R6 c45 wr int0");
    finish_op();
    start_op(1, 1, 1'b1, 1'b1, 5'd17, 16'h0, {11'd0, 5'd30, 16'hFFFE}, 16'h6B5A, "R6 c45 rd int1");
    finish_op();
    start_op(0, 2, 1'b1, 1'b0, 5'd31, 16'h0F0F, {11'd0, 5'd1, 16'h0000}, 16'h0, "R6 c45 wr ext2");
    finish_op();
    start_op(0, 0, 1'b1, 1'b1, 5'd4, 16'h0, {11'd0, 5'd7, 16'h8421}, 16'hF00D, "R6 c45 rd ext0");
    finish_op();

    // Start code while done is ignored
    gs = g;
    bus_wr(5'h0C, 32'd1);
    repeat (50) @(negedge clk);
    check("R3 start while done no edges", 32'(g), 32'(gs));
    bus_rd(5'h10, v); check("R3 done still set", v, 32'd1);

    // Code 3 starts nothing
    bus_wr(5'h0C, 32'd0);
    gs = g;
    bus_wr(5'h0C, 32'd3);
    repeat (50) @(negedge clk);
    check("R2 code 3 no edges", 32'(g), 32'(gs));
    bus_rd(5'h10, v); check("R2 code 3 status", v, 32'd0);

    // Abort mid-frame
    start_op(1, 0, 1'b0, 1'b0, 5'd2, 16'h0007, 32'd1, 16'h0, "R4 abort");
    repeat (40) @(negedge clk);
    bus_wr(5'h0C, 32'd0);
    check("R4 abort mdc low", 32'(mdc_o), 32'd0);
    check("R4 abort oe low", 32'(mdio_oe), 32'd0);
    bus_rd(5'h10, v); check("R4 abort status", v, 32'd0);
    gs = g;
    repeat (300) @(negedge clk);
    check("R4 abort no more edges", 32'(g), 32'(gs));

    // Parameter write during an access does not disturb it
    start_op(1, 1, 1'b0, 1'b0, 5'd3, 16'h1111, 32'd5, 16'h0, "R11 mid-run write");
    repeat (60) @(negedge clk);
    bus_wr(5'h00, (32'd1 << 21) | (32'd2 << 22) | 32'hBEEF);
    bus_wr(5'h08, 32'h001F_0000);
    finish_op();
    bus_rd(5'h00, v); check("R11 R1 new param stored", v, (32'd1 << 21) | (32'd2 << 22) | 32'hBEEF);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule